// File: doc/BRIEF.md
# Security Module Byte-FIFO Register Front-End

This block is the device side of a byte-wide register interface through which a host talks to a trusted security module. The host claims locality 0 through an access register and then works a polled handshake through a status register. It arms the block with command-ready, streams a command into a data port while watching data-expected, and starts execution with go. It then waits for data-available and drains the response through the same data port. A 16-bit burst count sits in the upper bytes of the status word and tells the host how many bytes it may move without polling again.

Command bytes land in a command buffer. The total length is taken from the big-endian field in bytes 2 to 5 of a 10-byte header, then clamped to at least the header size and at most the buffer depth. Once go is accepted, a stub engine fills a response buffer with a fixed-length reply, one byte per cycle. The reply echoes the two tag bytes, carries its own length in big-endian form and sets a zero result code.

The host port is a request stream with no back-pressure. Every request with `req_valid` high is taken in that cycle. A read answers exactly one cycle later with `rsp_valid`, and the host cannot stall the answer. Writes produce no answer.

Top module: `secmod_fifo_regs`

## Requirements
- R1: After reset the access byte (offset 0x00) reads 0x80, the status byte (0x18) reads 0x80, and the burst count bytes (0x19, 0x1A) read 0x00.
- R2: Writing 0x02 (bit 1) to offset 0x00 while the locality is inactive sets the pending bit (bit 2) for one cycle, so the access byte reads 0x84. The next cycle makes the locality active (bit 5), and the access byte reads 0xA0. Writing bit 5 while active releases the locality, and the access byte reads 0x80 again.
- R3: While the locality is inactive, writes to the status byte and the data port (0x24) have no effect. Reads of the data port return 0xFF and do not consume a response byte.
- R4: Writing bit 6 (command-ready) to the status byte from any state discards any command or response and enters the ready state. The status byte then reads 0xC0.
- R5: Data-expected (status bit 3) is set after each accepted command byte until the target count is reached. The target is 10 until byte 5 is written. After that it is the big-endian length in bytes 2 to 5, raised to 10 if smaller and cut to CMD_DEPTH if larger. Bytes beyond the target are ignored.
- R6: The burst count occupies status bits 8 to 23, with the low byte at 0x19 and the high byte at 0x1A. It equals the free command space during reception and the unread response bytes during sending, both capped at BURST_MAX. It is 0 in every other state.
- R7: Go (bit 5 written to 0x18) after the last command byte starts execution. While busy, the status byte reads 0x00 and the burst count reads 0. After RSP_LEN cycles the status byte reads 0x90. A go written while data-expected is set is ignored.
- R8: The response bytes, in order, are: command byte 0, command byte 1, RSP_LEN as a 4-byte big-endian value, and zeros in every remaining position.
- R9: Data-available (bit 4) clears once the final response byte has been read, leaving status 0x80. A later data-port read returns 0xFF.
- R10: Writing bit 1 (response-retry) to the status byte while sending, or after the response is drained, rewinds the response to its first byte and sets data-available.
- R11: The capability register at 0x14 to 0x17 reads 0x15, 0x00, 0x00, 0x00. Bit 0 advertises the data-available interrupt, bit 2 the locality-change interrupt and bit 4 the level-low interrupt.
- R12: Every read request produces `rsp_valid` with its data exactly one cycle later. Write requests produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register byte offset |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 8 | Read data |

## Verification
The embedded assertions watch the per-cycle invariants: the one-cycle read latency, the grant that follows a pending locality request, the release of the locality, the abort landing in the ready state, and the command count staying inside the buffer. They also check that data-expected and data-available never appear together, that the burst count is zero while busy, that a go written during data-expected leaves reception running, and that data-available falls after the last byte is read. The response contents, the length clamping at both ends, the capped burst values, the rewind on retry and the inertness of an inactive locality all depend on multi-step host sequences. Only the bench scenarios show those.

// File: rtl/smf_pkg.sv
package smf_pkg;
  // register byte offsets (host software decodes these)
  localparam logic [7:0] A_ACCESS   = 8'h00;
  localparam logic [7:0] A_CAP0     = 8'h14;
  localparam logic [7:0] A_CAP1     = 8'h15;
  localparam logic [7:0] A_CAP2     = 8'h16;
  localparam logic [7:0] A_CAP3     = 8'h17;
  localparam logic [7:0] A_STS      = 8'h18;
  localparam logic [7:0] A_BURST_LO = 8'h19;
  localparam logic [7:0] A_BURST_HI = 8'h1A;
  localparam logic [7:0] A_FIFO     = 8'h24;

  // capability low byte: data-avail int, locality-change int, level-low int
  localparam logic [7:0] CAP_LOW = 8'h15;

  // access register bits
  localparam int ACC_REQ   = 1;
  localparam int ACC_ACT   = 5;

  // status register bits
  localparam int STS_RDY   = 6;
  localparam int STS_GO    = 5;
  localparam int STS_RETRY = 1;

  localparam int unsigned HDR_BYTES = 10;
  localparam int unsigned LEN_FIRST = 2;
  localparam int unsigned LEN_LAST  = 5;
  localparam int unsigned BURST_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_SEND, ST_DONE
  } eng_state_t;
endpackage

// File: rtl/smf_locality.sv
module smf_locality (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       active,
  output logic [7:0] access_byte
);
  import smf_pkg::*;

  logic pending;
  logic want, drop;
  logic [5:0] unused_bits;

  assign unused_bits = {wdata[7:6], wdata[4:2], wdata[0]};
  assign want = wr_en && wdata[ACC_REQ] && !active && !pending;
  assign drop = wr_en && wdata[ACC_ACT] && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      active  <= 1'b0;
    end else if (drop) begin
      active <= 1'b0;
    end else if (pending) begin
      pending <= 1'b0;
      active  <= 1'b1;
    end else if (want) begin
      pending <= 1'b1;
    end
  end

  assign access_byte = {1'b1, 1'b0, active, 1'b0, 1'b0, pending, 1'b0, 1'b0};

  assert_grant_after_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (active && !pending));
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[ACC_ACT] && active) |=> !active);
endmodule

// File: rtl/smf_bytebuf.sv
module smf_bytebuf #(
  parameter int DEPTH = 32,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smf_engine.sv
module smf_engine #(
  parameter int CMD_DEPTH = 32,
  parameter int RSP_LEN   = 10,
  parameter int BURST_MAX = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready_wr,
  input  logic       go_wr,
  input  logic       retry_wr,
  input  logic       data_wr,
  input  logic [7:0] data_byte,
  input  logic       data_rd,
  output logic [7:0] status_byte,
  output logic [smf_pkg::BURST_W-1:0] burst,
  output logic [7:0] fifo_byte
);
  import smf_pkg::*;

  localparam int CAW  = (CMD_DEPTH > 1) ? $clog2(CMD_DEPTH) : 1;
  localparam int CNT_W = $clog2(CMD_DEPTH + 1);
  localparam int RAW  = (RSP_LEN > 1) ? $clog2(RSP_LEN) : 1;
  localparam int RP_W = $clog2(RSP_LEN + 1);
  localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(CMD_DEPTH);
  localparam logic [RP_W-1:0]  LAST_R  = RP_W'(RSP_LEN - 1);

  eng_state_t state;
  logic [CNT_W-1:0] count, target;
  logic [31:0] len_q;
  logic [RP_W-1:0] gcnt, rptr;
  logic take_byte, len_slot, expect_q, avail_q;
  logic [7:0] cmd_q, rsp_q, gen_byte;
  logic [31:0] room;

  // target byte count of the command being received
  always_comb begin
    if (count < CNT_W'(LEN_LAST + 1))      target = HDR_C;
    else if (len_q < 32'(HDR_BYTES))       target = HDR_C;
    else if (len_q > 32'(CMD_DEPTH))       target = DEPTH_C;
    else                                   target = CNT_W'(len_q);
  end

  assign take_byte = data_wr && (state == ST_READY || state == ST_RECV) && (count < target);
  assign len_slot  = (count >= CNT_W'(LEN_FIRST)) && (count <= CNT_W'(LEN_LAST));

  smf_bytebuf #(.DEPTH(CMD_DEPTH)) u_cmd_buf (
    .clk   (clk),
    .we    (take_byte),
    .waddr (CAW'(count)),
    .wdata (data_byte),
    .raddr (CAW'(gcnt[0])),
    .rdata (cmd_q)
  );

  // stub reply: tag echo, big-endian own length, zero result
  always_comb begin
    gen_byte = 8'h00;
    if (gcnt < RP_W'(2))
      gen_byte = cmd_q;
    else if (gcnt <= RP_W'(LEN_LAST))
      gen_byte = 8'(32'(RSP_LEN) >> (8 * (LEN_LAST - 32'(gcnt))));
  end

  smf_bytebuf #(.DEPTH(RSP_LEN)) u_rsp_buf (
    .clk   (clk),
    .we    (state == ST_EXEC),
    .waddr (RAW'(gcnt)),
    .wdata (gen_byte),
    .raddr (RAW'(rptr)),
    .rdata (rsp_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      count <= '0;
      len_q <= '0;
      gcnt  <= '0;
      rptr  <= '0;
    end else if (ready_wr) begin
      state <= ST_READY;
      count <= '0;
      len_q <= '0;
    end else begin
      case (state)
        ST_READY, ST_RECV: begin
          if (take_byte) begin
            count <= count + 1'b1;
            state <= ST_RECV;
            if (len_slot) len_q <= {len_q[23:0], data_byte};
          end else if (go_wr && state == ST_RECV && count == target) begin
            state <= ST_EXEC;
            gcnt  <= '0;
          end
        end
        ST_EXEC: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == LAST_R) begin
            state <= ST_SEND;
            rptr  <= '0;
          end
        end
        ST_SEND: begin
          if (retry_wr) rptr <= '0;
          else if (data_rd) begin
            if (rptr == LAST_R) state <= ST_DONE;
            else rptr <= rptr + 1'b1;
          end
        end
        ST_DONE: begin
          if (retry_wr) begin
            state <= ST_SEND;
            rptr  <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign expect_q = (state == ST_RECV) && (count < target);
  assign avail_q  = (state == ST_SEND);
  assign status_byte = {state != ST_EXEC, state == ST_READY || state == ST_RECV,
                        1'b0, avail_q, expect_q, 3'b000};

  always_comb begin
    if (state == ST_READY || state == ST_RECV) room = 32'(CMD_DEPTH) - 32'(count);
    else if (state == ST_SEND)                 room = 32'(RSP_LEN) - 32'(rptr);
    else                                       room = 32'd0;
  end
  assign burst = (room > 32'(BURST_MAX)) ? BURST_W'(BURST_MAX) : BURST_W'(room);
  assign fifo_byte = avail_q ? rsp_q : 8'hFF;

  assert_abort_to_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_wr |=> (state == ST_READY && count == '0));
  assert_count_in_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_C);
  assert_busy_burst_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |-> (burst == '0 && !status_byte[7]));
  assert_go_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && expect_q && !ready_wr) |=> (state == ST_RECV));
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_byte[4] && status_byte[3]));
  assert_avail_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_q && data_rd && !retry_wr && !ready_wr && rptr == LAST_R) |=> !status_byte[4]);
endmodule

// File: rtl/secmod_fifo_regs.sv
module secmod_fifo_regs #(
  parameter int ADDR_W    = 8,
  parameter int CMD_DEPTH = 32,
  parameter int RSP_LEN   = 10,
  parameter int BURST_MAX = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata
);
  import smf_pkg::*;

  logic wr_any, rd_any, active;
  logic loc_wr, sts_wr, ready_wr, go_wr, retry_wr, data_wr, data_rd;
  logic [7:0] access_byte, status_byte, fifo_byte, rd_next;
  logic [BURST_W-1:0] burst;

  assign wr_any = req_valid && req_write;
  assign rd_any = req_valid && !req_write;

  assign loc_wr   = wr_any && (req_addr == ADDR_W'(A_ACCESS));
  assign sts_wr   = wr_any && (req_addr == ADDR_W'(A_STS)) && active;
  assign ready_wr = sts_wr && req_wdata[STS_RDY];
  assign go_wr    = sts_wr && req_wdata[STS_GO] && !req_wdata[STS_RDY];
  assign retry_wr = sts_wr && req_wdata[STS_RETRY] && !req_wdata[STS_GO] && !req_wdata[STS_RDY];
  assign data_wr  = wr_any && (req_addr == ADDR_W'(A_FIFO)) && active;
  assign data_rd  = rd_any && (req_addr == ADDR_W'(A_FIFO)) && active;

  smf_locality u_loc (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (loc_wr),
    .wdata       (req_wdata),
    .active      (active),
    .access_byte (access_byte)
  );

  smf_engine #(
    .CMD_DEPTH (CMD_DEPTH),
    .RSP_LEN   (RSP_LEN),
    .BURST_MAX (BURST_MAX)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready_wr    (ready_wr),
    .go_wr       (go_wr),
    .retry_wr    (retry_wr),
    .data_wr     (data_wr),
    .data_byte   (req_wdata),
    .data_rd     (data_rd),
    .status_byte (status_byte),
    .burst       (burst),
    .fifo_byte   (fifo_byte)
  );

  always_comb begin
    rd_next = 8'h00;
    if      (req_addr == ADDR_W'(A_ACCESS))   rd_next = access_byte;
    else if (req_addr == ADDR_W'(A_CAP0))     rd_next = CAP_LOW;
    else if (req_addr == ADDR_W'(A_CAP1))     rd_next = 8'h00;
    else if (req_addr == ADDR_W'(A_CAP2))     rd_next = 8'h00;
    else if (req_addr == ADDR_W'(A_CAP3))     rd_next = 8'h00;
    else if (req_addr == ADDR_W'(A_STS))      rd_next = status_byte;
    else if (req_addr == ADDR_W'(A_BURST_LO)) rd_next = burst[7:0];
    else if (req_addr == ADDR_W'(A_BURST_HI)) rd_next = burst[15:8];
    else if (req_addr == ADDR_W'(A_FIFO))     rd_next = active ? fifo_byte : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else begin
      rsp_valid <= rd_any;
      if (rd_any) rsp_rdata <= rd_next;
    end
  end

  assert_read_answered_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid);
  assert_write_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rsp_valid);
endmodule

// File: tb/secmod_fifo_regs_bench.sv
`timescale 1ns/1ps
module secmod_fifo_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic rsp_valid;
  logic [7:0] rsp_rdata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  secmod_fifo_regs u_secmod_fifo_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  typedef struct packed {
    logic       rd;
    logic [7:0] addr;
    logic [7:0] val;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 8'h80, 8'd1},   // R1 access after reset
    '{1'b1, 8'h18, 8'h80, 8'd1},   // R1 status after reset
    '{1'b1, 8'h19, 8'h00, 8'd1},   // R1 burst low after reset
    '{1'b1, 8'h14, 8'h15, 8'd11},  // R11 capability low byte
    '{1'b1, 8'h17, 8'h00, 8'd11},  // R11 capability high byte
    '{1'b0, 8'h18, 8'h40, 8'd3},   // R3 command-ready without locality
    '{1'b1, 8'h18, 8'h80, 8'd3},   // R3 status untouched
    '{1'b0, 8'h00, 8'h02, 8'd2},   // R2 request locality
    '{1'b1, 8'h00, 8'h84, 8'd2},   // R2 pending
    '{1'b1, 8'h00, 8'hA0, 8'd2},   // R2 active
    '{1'b0, 8'h18, 8'h40, 8'd4},   // R4 command-ready
    '{1'b1, 8'h18, 8'hC0, 8'd4},   // R4 ready status
    '{1'b1, 8'h19, 8'h14, 8'd6},   // R6 free space capped at 20
    '{1'b1, 8'h1A, 8'h00, 8'd6}    // R6 burst high byte
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  function automatic logic [7:0] cbyte(input int i, input logic [31:0] lf);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h01;
    if (i >= 2 && i <= 5) return lf[8*(5-i) +: 8];
    return 8'(i);
  endfunction

  // write bytes [from,to) of a command, checking data-expected after each (R5)
  task automatic send(input logic [31:0] lf, input int from, input int to, input int tgt);
    logic [7:0] s;
    for (int i = from; i < to; i++) begin
      wr(8'h24, cbyte(i, lf));
      rd(8'h18, s);
      chk($sformatf("R5 expect after byte %0d", i + 1), s, ((i + 1) < tgt) ? 8'hC8 : 8'hC0);
    end
  endtask

  task automatic wait_avail(output logic [7:0] s);
    s = 8'h00;
    for (int k = 0; k < 40; k++) begin
      rd(8'h18, s);
      if (s[4]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_rsp [10];
    exp_rsp = '{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].rd) begin
        rd(VEC[v].addr, d);
        chk($sformatf("R%0d vector %0d", VEC[v].req, v), d, VEC[v].val);
      end else begin
        wr(VEC[v].addr, VEC[v].val);
      end
    end

    // R12: write gives no response, read gives one a cycle later
    wr(8'h19, 8'h00);
    chk("R12 no response to write", {7'd0, rsp_valid}, 8'h01 & {7'd0, 1'b0});
    rd(8'h19, d);
    chk("R12 read response valid", {7'd0, rsp_valid}, 8'h01);

    // 12-byte command, go attempted early
    send(32'd12, 0, 11, 12);
    wr(8'h18, 8'h20);
    rd(8'h18, d);
    chk("R7 go ignored while expecting", d, 8'hC8);
    send(32'd12, 11, 12, 12);
    rd(8'h19, d);
    chk("R6 free space after 12 bytes", d, 8'h14);
    wr(8'h18, 8'h20);
    rd(8'h18, d);
    chk("R7 busy status", d, 8'h00);
    rd(8'h19, d);
    chk("R6 burst zero while busy", d, 8'h00);
    wait_avail(d);
    chk("R7 data available", d, 8'h90);
    rd(8'h19, d);
    chk("R6 remaining bytes", d, 8'h0A);
    for (int i = 0; i < 10; i++) begin
      rd(8'h24, d);
      chk($sformatf("R8 response byte %0d", i), d, exp_rsp[i]);
      if (i == 2) begin
        rd(8'h19, d);
        chk("R6 remaining after 3 reads", d, 8'h07);
      end
    end
    rd(8'h18, d);
    chk("R9 avail cleared", d, 8'h80);
    rd(8'h24, d);
    chk("R9 empty data read", d, 8'hFF);

    // R10 retry rewinds
    wr(8'h18, 8'h02);
    rd(8'h18, d);
    chk("R10 avail after retry", d, 8'h90);
    rd(8'h24, d);
    chk("R10 first byte again", d, 8'h80);
    rd(8'h24, d);
    chk("R10 second byte again", d, 8'h01);

    // R4 abort while sending
    wr(8'h18, 8'h40);
    rd(8'h18, d);
    chk("R4 abort from send", d, 8'hC0);
    rd(8'h19, d);
    chk("R4 burst after abort", d, 8'h14);

    // R5 short length field raised to header size
    send(32'd4, 0, 10, 10);

    // R5 long length field cut to buffer depth
    wr(8'h18, 8'h40);
    send(32'h100, 0, 32, 32);
    wr(8'h24, 8'h5A);
    rd(8'h18, d);
    chk("R5 extra byte ignored status", d, 8'hC0);
    rd(8'h19, d);
    chk("R5 buffer full burst", d, 8'h00);
    wr(8'h18, 8'h20);
    wait_avail(d);
    chk("R7 avail after full command", d, 8'h90);
    rd(8'h24, d);
    chk("R8 tag echo", d, 8'h80);

    // R3 inactive locality leaves the engine alone
    wr(8'h00, 8'h20);
    rd(8'h00, d);
    chk("R2 released", d, 8'h80);
    rd(8'h24, d);
    chk("R3 data read without locality", d, 8'hFF);
    wr(8'h18, 8'h40);
    rd(8'h18, d);
    chk("R3 status unchanged", d, 8'h90);
    wr(8'h00, 8'h02);
    rd(8'h00, d);
    rd(8'h24, d);
    chk("R3 no byte consumed", d, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule